// File: doc/BRIEF.md
# Handshake Protocol Bridge Queue

This block joins two four-phase handshake buses that share one clock. A sender on the input side offers a write word: an address, a data value and a control code. The input controller takes the word into a first-in first-out queue and completes the four-phase exchange with it. The output controller takes words from the head of the queue and offers each one to a receiver on the output side, using a second four-phase exchange. The two exchanges run independently of each other.

The queue decouples the two buses. When the queue is full, the input side holds back its acknowledge, which stalls the sender. When the queue is empty, the output side does not offer a word. Each side has a one-cycle interrupt pulse that marks the end of a completed exchange. The interrupt can wake a local processor or be counted by one.

Top module: `hsq_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, `snd_ack`, `rcv_rdy`, `snd_irq` and `rcv_irq` are low, and `rcv_ctrl` is 2'b00.
- R2: When `snd_rdy` is sampled high with `snd_ctrl` equal to the write-word code 2'b01 and the queue is not full, `snd_ack` is high one cycle later and the word {`snd_addr`, `snd_data`} is stored in the queue.
- R3: Once `snd_ack` is high, it falls one cycle after `snd_rdy` is sampled low. In that same cycle `snd_irq` is high, and `snd_irq` is high for exactly one cycle.
- R4: A request whose `snd_ctrl` is not 2'b01 is ignored. `snd_ack` stays low and no word reaches the output side.
- R5: While the output side holds one unacknowledged word, the queue takes `DEPTH` more words. After that, `snd_ack` stays low for a waiting request until the receiver drains a word, and then the request is accepted.
- R6: `rcv_rdy` rises only when the queue holds a word. While `rcv_rdy` is high, `rcv_ctrl` is 2'b01. While `rcv_rdy` is low, `rcv_ctrl` is 2'b00.
- R7: `rcv_addr` and `rcv_data` stay stable while `rcv_rdy` is high. `rcv_rdy` falls one cycle after `rcv_ack` is sampled high.
- R8: After `rcv_rdy` falls, the output side waits for `rcv_ack` to be sampled low. In the next cycle `rcv_irq` is high for exactly one cycle, and only after that is a new word offered.
- R9: Words leave on the output side in the order they were accepted on the input side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_rdy | input | 1 | Input-side request, held with a valid word |
| snd_ctrl | input | 2 | Input-side control code (2'b01 is write-word) |
| snd_addr | input | ADDR_W | Input-side address |
| snd_data | input | DATA_W | Input-side data |
| snd_ack | output | 1 | Input-side acknowledge |
| snd_irq | output | 1 | One-cycle pulse when an input exchange ends |
| rcv_rdy | output | 1 | Output-side request, a word is offered |
| rcv_ctrl | output | 2 | Output-side control code |
| rcv_addr | output | ADDR_W | Output-side address |
| rcv_data | output | DATA_W | Output-side data |
| rcv_ack | input | 1 | Output-side acknowledge from the receiver |
| rcv_irq | output | 1 | One-cycle pulse when an output exchange ends |

## Verification
The bench stalls the receiver and fills the queue plus the output register, then raises one more request. A design that counted the queue wrongly would acknowledge into a full queue and overwrite an unread word, or it would deadlock and never accept the request after the drain. A request with a non-write control code must produce neither an acknowledge nor an output word, so a design that ignored the control code would emit an unexpected word. A scoreboard checks the order and contents of the words across back-to-back and stalled traffic, which exposes pointer wrap errors. Timed checks on both release phases catch a design that ends an exchange early or pulses its interrupt for more than one cycle.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
    typedef logic [1:0] ctrl_t;
    localparam ctrl_t CTRL_IDLE   = 2'b00;
    localparam ctrl_t CTRL_WRWORD = 2'b01;

    typedef enum logic {
        RX_IDLE,
        RX_HOLD
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_WAIT_ACK,
        TX_WAIT_REL
    } tx_state_e;
endpackage

// File: rtl/hsq_fifo.sv
module hsq_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_word_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_regs_t;

    fifo_regs_t cur_q, nxt_d;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (cur_q.cnt == FULL_CNT);
    assign empty_o = (cur_q.cnt == '0);
    assign head_o  = mem_q[cur_q.rp];
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;

    always_comb begin
        nxt_d = cur_q;
        if (do_push) nxt_d.wp = step(cur_q.wp);
        if (do_pop)  nxt_d.rp = step(cur_q.rp);
        case ({do_push, do_pop})
            2'b10:   nxt_d.cnt = cur_q.cnt + 1'b1;
            2'b01:   nxt_d.cnt = cur_q.cnt - 1'b1;
            default: nxt_d.cnt = cur_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[cur_q.wp] <= push_word_i;
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= FULL_CNT);
endmodule

// File: rtl/hsq_rx.sv
module hsq_rx
    import hsq_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         snd_rdy_i,
    input  ctrl_t        snd_ctrl_i,
    input  logic [W-1:0] snd_word_i,
    input  logic         full_i,
    output logic         push_o,
    output logic [W-1:0] push_word_o,
    output logic         ack_o,
    output logic         irq_o
);
    typedef struct packed {
        rx_state_e state;
        logic      ack;
        logic      irq;
    } rx_regs_t;

    rx_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.irq = 1'b0;
        push_o    = 1'b0;
        case (cur_q.state)
            RX_IDLE: begin
                if (snd_rdy_i && snd_ctrl_i == CTRL_WRWORD && !full_i) begin
                    push_o      = 1'b1;
                    nxt_d.ack   = 1'b1;
                    nxt_d.state = RX_HOLD;
                end
            end
            RX_HOLD: begin
                if (!snd_rdy_i) begin
                    nxt_d.ack   = 1'b0;
                    nxt_d.irq   = 1'b1;
                    nxt_d.state = RX_IDLE;
                end
            end
            default: nxt_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign push_word_o = snd_word_i;
    assign ack_o       = cur_q.ack;
    assign irq_o       = cur_q.irq;

    p_ack_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(!full_i));
    p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> $past(!snd_rdy_i));
    p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    p_ignore_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_o && snd_ctrl_i != CTRL_WRWORD) |=> !ack_o);
endmodule

// File: rtl/hsq_tx.sv
module hsq_tx
    import hsq_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         empty_i,
    input  logic [W-1:0] head_i,
    output logic         pop_o,
    input  logic         rcv_ack_i,
    output logic         rdy_o,
    output ctrl_t        ctrl_o,
    output logic [W-1:0] word_o,
    output logic         irq_o
);
    typedef struct packed {
        tx_state_e    state;
        logic         rdy;
        logic         irq;
        logic [W-1:0] word;
    } tx_regs_t;

    tx_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.irq = 1'b0;
        pop_o     = 1'b0;
        case (cur_q.state)
            TX_IDLE: begin
                if (!empty_i) begin
                    pop_o       = 1'b1;
                    nxt_d.word  = head_i;
                    nxt_d.rdy   = 1'b1;
                    nxt_d.state = TX_WAIT_ACK;
                end
            end
            TX_WAIT_ACK: begin
                if (rcv_ack_i) begin
                    nxt_d.rdy   = 1'b0;
                    nxt_d.state = TX_WAIT_REL;
                end
            end
            TX_WAIT_REL: begin
                if (!rcv_ack_i) begin
                    nxt_d.irq   = 1'b1;
                    nxt_d.state = TX_IDLE;
                end
            end
            default: nxt_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rdy_o  = cur_q.rdy;
    assign ctrl_o = cur_q.rdy ? CTRL_WRWORD : CTRL_IDLE;
    assign word_o = cur_q.word;
    assign irq_o  = cur_q.irq;

    p_offer_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> $past(!empty_i));
    p_word_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && $past(rdy_o)) |-> $stable(word_o));
    p_drop_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_o) |-> $past(rcv_ack_i));
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    p_irq_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(!rcv_ack_i) && !rdy_o));
endmodule

// File: rtl/hsq_bridge.sv
module hsq_bridge
    import hsq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snd_rdy,
    input  logic [1:0]        snd_ctrl,
    input  logic [ADDR_W-1:0] snd_addr,
    input  logic [DATA_W-1:0] snd_data,
    output logic              snd_ack,
    output logic              snd_irq,
    output logic              rcv_rdy,
    output logic [1:0]        rcv_ctrl,
    output logic [ADDR_W-1:0] rcv_addr,
    output logic [DATA_W-1:0] rcv_data,
    input  logic              rcv_ack,
    output logic              rcv_irq
);
    localparam int WW = ADDR_W + DATA_W;

    logic          push, pop, full, empty;
    logic [WW-1:0] push_word, head_word, out_word;

    hsq_rx #(.W(WW)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .snd_rdy_i   (snd_rdy),
        .snd_ctrl_i  (snd_ctrl),
        .snd_word_i  ({snd_addr, snd_data}),
        .full_i      (full),
        .push_o      (push),
        .push_word_o (push_word),
        .ack_o       (snd_ack),
        .irq_o       (snd_irq)
    );

    hsq_fifo #(.W(WW), .DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_word_i (push_word),
        .pop_i       (pop),
        .head_o      (head_word),
        .full_o      (full),
        .empty_o     (empty)
    );

    hsq_tx #(.W(WW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .empty_i   (empty),
        .head_i    (head_word),
        .pop_o     (pop),
        .rcv_ack_i (rcv_ack),
        .rdy_o     (rcv_rdy),
        .ctrl_o    (rcv_ctrl),
        .word_o    (out_word),
        .irq_o     (rcv_irq)
    );

    assign rcv_addr = out_word[WW-1:DATA_W];
    assign rcv_data = out_word[DATA_W-1:0];

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!snd_ack && !rcv_rdy && !snd_irq && !rcv_irq));
endmodule

// File: tb/hsq_bridge_test.sv
module hsq_bridge_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snd_rdy = 1'b0;
    logic [1:0] snd_ctrl = 2'b00;
    logic [AW-1:0] snd_addr = '0;
    logic [DW-1:0] snd_data = '0;
    logic snd_ack, snd_irq, rcv_rdy, rcv_irq;
    logic [1:0] rcv_ctrl;
    logic [AW-1:0] rcv_addr;
    logic [DW-1:0] rcv_data;
    logic rcv_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit stall = 1'b0;
    bit done = 1'b0;
    logic [AW+DW-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hsq_bridge #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .snd_rdy(snd_rdy), .snd_ctrl(snd_ctrl), .snd_addr(snd_addr),
        .snd_data(snd_data), .snd_ack(snd_ack), .snd_irq(snd_irq),
        .rcv_rdy(rcv_rdy), .rcv_ctrl(rcv_ctrl), .rcv_addr(rcv_addr),
        .rcv_data(rcv_data), .rcv_ack(rcv_ack), .rcv_irq(rcv_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: complete one input-side exchange, expecting ack in one cycle
    task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int waited = 0;
        @(negedge clk);
        exp_q.push_back({a, d});
        snd_rdy = 1'b1; snd_ctrl = 2'b01; snd_addr = a; snd_data = d;
        do begin
            @(negedge clk);
            waited++;
        end while (!snd_ack && waited < 200);
        chk(waited == 1, "R2 ack latency", waited, 1);
        snd_rdy = 1'b0;
        @(negedge clk);
        chk(snd_ack == 1'b0, "R3 ack release", snd_ack, 0);
        chk(snd_irq == 1'b1, "R3 irq pulse", snd_irq, 1);
        @(negedge clk);
        chk(snd_irq == 1'b0, "R3 irq width", snd_irq, 0);
    endtask

    // Monitor: scoreboard compare and output-side exchange
    initial begin
        forever begin
            @(negedge clk);
            if (rcv_rdy && !stall) begin
                chk(rcv_ctrl == 2'b01, "R6 write code", rcv_ctrl, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected word", {rcv_addr, rcv_data}, 0);
                end else begin
                    logic [AW+DW-1:0] e;
                    e = exp_q.pop_front();
                    chk({rcv_addr, rcv_data} == e, "R9 order/content",
                        {rcv_addr, rcv_data}, e);
                end
                rcv_ack = 1'b1;
                @(negedge clk);
                chk(rcv_rdy == 1'b0, "R7 ready drop", rcv_rdy, 0);
                rcv_ack = 1'b0;
                @(negedge clk);
                chk(rcv_irq == 1'b1, "R8 irq pulse", rcv_irq, 1);
                chk(rcv_rdy == 1'b0, "R8 no offer before irq", rcv_rdy, 0);
                @(negedge clk);
                chk(rcv_irq == 1'b0, "R8 irq width", rcv_irq, 0);
            end
        end
    end

    task automatic drain();
        int t = 0;
        while ((exp_q.size() != 0 || rcv_rdy) && t < 500) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all words delivered", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!snd_ack && !rcv_rdy && !snd_irq && !rcv_irq, "R1 reset outputs",
            {snd_ack, rcv_rdy, snd_irq, rcv_irq}, 0);
        chk(rcv_ctrl == 2'b00, "R1 reset ctrl", rcv_ctrl, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!snd_ack && !rcv_rdy && !snd_irq && !rcv_irq, "R1 after reset",
            {snd_ack, rcv_rdy, snd_irq, rcv_irq}, 0);

        // single and back-to-back words
        send(8'h11, 16'hA001);
        send(8'h22, 16'hB002);
        send(8'h33, 16'hC003);
        send(8'hFF, 16'h0000);
        send(8'h00, 16'hFFFF);
        drain();
        chk(rcv_rdy == 1'b0, "R6 idle when empty", rcv_rdy, 0);
        chk(rcv_ctrl == 2'b00, "R6 idle code", rcv_ctrl, 0);

        // non-write control code ignored
        @(negedge clk);
        snd_rdy = 1'b1; snd_ctrl = 2'b10; snd_addr = 8'h5A; snd_data = 16'h5A5A;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(snd_ack == 1'b0, "R4 no ack for code 10", snd_ack, 0);
        end
        snd_ctrl = 2'b00;
        repeat (2) @(negedge clk);
        chk(snd_ack == 1'b0, "R4 no ack for code 00", snd_ack, 0);
        snd_rdy = 1'b0;
        repeat (4) @(negedge clk);
        chk(rcv_rdy == 1'b0, "R4 nothing offered", rcv_rdy, 0);

        // fill: one word held at output, DEPTH in the queue
        stall = 1'b1;
        for (int i = 0; i <= DEPTH; i++) send(AW'(8'h40 + i), DW'(16'h1000 + i));
        @(negedge clk);
        exp_q.push_back({8'h99, 16'h9999});
        snd_rdy = 1'b1; snd_ctrl = 2'b01; snd_addr = 8'h99; snd_data = 16'h9999;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(snd_ack == 1'b0, "R5 no ack when full", snd_ack, 0);
        end
        stall = 1'b0;
        begin
            int t = 0;
            while (!snd_ack && t < 50) begin
                @(negedge clk);
                t++;
            end
        end
        chk(snd_ack == 1'b1, "R5 accepted after drain", snd_ack, 1);
        snd_rdy = 1'b0;
        @(negedge clk);
        chk(snd_irq == 1'b1, "R3 irq after full", snd_irq, 1);
        drain();

        // queue wrap-around with a second burst
        for (int i = 0; i < 7; i++) send(AW'(8'h70 + i), DW'(16'h7700 ^ (i * 16'h0111)));
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule